// File: doc/BRIEF.md
# Scan Chain with Output Freeze

This block is a serial test chain of one-bit storage stages. Each stage has a flip-flop that either loads its parallel functional input or takes the value of the stage before it, chosen by a single shift-select input. The first stage takes the serial input pin, and the flip-flop of the last stage drives the serial output pin. All stages therefore form one shift register when shift-select is high, and a row of ordinary registers when it is low.

Each stage also has a freeze register placed between its flip-flop and the parallel output seen by downstream logic. While the freeze input is high, every parallel output keeps the value its flip-flop had when freeze was raised. The flip-flops behind it keep capturing or shifting as usual. Downstream logic then sees no toggling while test data moves through the chain, which cuts switching power during shifting. When freeze is low, each parallel output shows its flip-flop directly.

A test controller raises freeze, shifts a pattern in with shift-select high, and then either releases freeze to apply the pattern or captures a response and shifts it out while the outputs stay still.

Top module: `shc_chain`

## Requirements
- R1: After one or more clock edges with `rst_n` low, every parallel output and the serial output read 0.
- R2: On a clock edge with `rst_n` high and `shift_en_i` = 0, stage k's flip-flop loads `func_d_i[k]` for every k.
- R3: On a clock edge with `rst_n` high and `shift_en_i` = 1, stage 0's flip-flop loads `scan_in_i` and stage k's flip-flop loads the value of stage k-1's flip-flop, for k from 1 to STAGES-1.
- R4: `scan_out_o` equals the flip-flop of stage STAGES-1 at all times, whether `freeze_i` is high or low.
- R5: While `freeze_i` is low, `func_q_o[k]` equals the current value of stage k's flip-flop, including in the cycle right after a capture or shift edge.
- R6: While `freeze_i` is high, `func_q_o` keeps the value it had just before `freeze_i` rose, across any number of capture or shift edges.
- R7: `freeze_i` has no effect on the flip-flops: captures and shifts made while it is high are seen in `func_q_o` as soon as it falls.
- R8: When `freeze_i` falls, `func_q_o` shows the flip-flop values in that same cycle, without waiting for a clock edge.
- R9: A reset edge taken while `freeze_i` is high also clears the frozen outputs, so `func_q_o` reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_en_i | input | 1 | 1: shift the chain, 0: capture the functional inputs |
| freeze_i | input | 1 | 1: hold the parallel outputs at their last value |
| scan_in_i | input | 1 | Serial data into stage 0 |
| func_d_i | input | STAGES | Parallel functional inputs, bit k feeds stage k |
| func_q_o | output | STAGES | Parallel outputs toward downstream logic, bit k from stage k |
| scan_out_o | output | 1 | Serial data from the last stage's flip-flop |

## Verification
Two functions of this block meet in one cycle: a freeze change and a capture or shift edge, and likewise a reset edge and a high freeze. The random phase toggles `freeze_i`, `shift_en_i` and an occasional reset independently each cycle, so freeze falls right after a shift edge, rises in the same cycle as a capture, and stays high across resets. A bench model of the flip-flops and frozen values predicts `func_q_o` and `scan_out_o`, which are checked after every change of inputs and after every edge. Directed sequences pin down the value kept across a full shift of the chain and the value seen at the moment freeze is released.

// File: rtl/shc_pkg.sv
// Package: shared types and helpers for the scan chain with output freeze.
// Assumes nothing beyond a 1-bit stage; the chain length is a top parameter.
package shc_pkg;

    // Operating mode of a stage flip-flop, decoded from the shift-select input.
    typedef enum logic {
        MODE_CAPTURE = 1'b0,
        MODE_SHIFT   = 1'b1
    } shc_mode_e;

    // Source of a parallel output: live flip-flop or frozen copy.
    typedef enum logic {
        OUT_LIVE   = 1'b0,
        OUT_FROZEN = 1'b1
    } shc_out_src_e;

    // Decode the shift-select pin into a mode.
    function automatic shc_mode_e shc_decode_mode(input logic shift_en);
        return shift_en ? MODE_SHIFT : MODE_CAPTURE;
    endfunction

    // Decode the freeze pin into an output source.
    function automatic shc_out_src_e shc_decode_src(input logic freeze);
        return freeze ? OUT_FROZEN : OUT_LIVE;
    endfunction

endpackage

// File: rtl/shc_mux_ff.sv
// Module: multiplexed storage flip-flop of one stage.
// Loads the functional bit in capture mode, the serial bit in shift mode.
// Exposes its next-state value so the freeze register can track it.
// Assumes a synchronous active-low reset.
module shc_mux_ff
    import shc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  shc_mode_e mode_i,
    input  logic      func_d_i,
    input  logic      ser_d_i,
    output logic      nxt_o,
    output logic      q_o
);

    logic q_r;

    // Select the value the flip-flop takes at the next edge.
    always_comb begin
        unique case (mode_i)
            MODE_SHIFT:   nxt_o = ser_d_i;
            MODE_CAPTURE: nxt_o = func_d_i;
            default:      nxt_o = func_d_i;
        endcase
    end

    // Store the selected value, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= 1'b0;
        end else begin
            q_r <= nxt_o;
        end
    end

    assign q_o = q_r;

endmodule

// File: rtl/shc_freeze_reg.sv
// Module: freeze register and output selector of one stage.
// While freeze is low it tracks the flip-flop's next state, so it always
// equals the flip-flop after an edge; while freeze is high it keeps its value.
// The output picks the live flip-flop when freeze is low and the frozen copy
// when freeze is high. Assumes a synchronous active-low reset.
module shc_freeze_reg
    import shc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  shc_out_src_e src_i,
    input  logic         ff_nxt_i,
    input  logic         ff_q_i,
    output logic         out_o
);

    logic frz_r;

    // Follow the flip-flop's next value unless the output is frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frz_r <= 1'b0;
        end else if (src_i == OUT_LIVE) begin
            frz_r <= ff_nxt_i;
        end
    end

    // Drive the stage output from the live or the frozen value.
    always_comb begin
        unique case (src_i)
            OUT_FROZEN: out_o = frz_r;
            OUT_LIVE:   out_o = ff_q_i;
            default:    out_o = ff_q_i;
        endcase
    end

endmodule

// File: rtl/shc_cell.sv
// Module: one stage of the chain, a multiplexed flip-flop plus its freeze
// register. The serial output is taken from the flip-flop, never from the
// frozen output, so shifting goes on while the output is held.
module shc_cell
    import shc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  shc_mode_e    mode_i,
    input  shc_out_src_e src_i,
    input  logic         func_d_i,
    input  logic         ser_d_i,
    output logic         ser_q_o,
    output logic         func_q_o
);

    logic ff_nxt;
    logic ff_q;

    shc_mux_ff u_ff (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode_i),
        .func_d_i (func_d_i),
        .ser_d_i  (ser_d_i),
        .nxt_o    (ff_nxt),
        .q_o      (ff_q)
    );

    shc_freeze_reg u_frz (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .ff_nxt_i (ff_nxt),
        .ff_q_i   (ff_q),
        .out_o    (func_q_o)
    );

    assign ser_q_o = ff_q;

endmodule

// File: rtl/shc_chain.sv
// Module: top of the scan chain with output freeze.
// STAGES cells are linked so that stage k's flip-flop feeds stage k+1's
// serial input; stage 0 takes scan_in_i and the last flip-flop drives
// scan_out_o. Assumes STAGES >= 2 and a synchronous active-low reset.
module shc_chain
    import shc_pkg::*;
#(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en_i,
    input  logic              freeze_i,
    input  logic              scan_in_i,
    input  logic [STAGES-1:0] func_d_i,
    output logic [STAGES-1:0] func_q_o,
    output logic              scan_out_o
);

    localparam int LAST = STAGES - 1;

    shc_mode_e    mode;
    shc_out_src_e src;
    logic [STAGES-1:0] ser_in;
    logic [STAGES-1:0] ser_q;

    // Decode the control pins once for all stages.
    always_comb begin
        mode = shc_decode_mode(shift_en_i);
        src  = shc_decode_src(freeze_i);
    end

    // Serial links: stage 0 from the pin, stage k from stage k-1.
    assign ser_in = {ser_q[LAST-1:0], scan_in_i};

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        shc_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_i   (mode),
            .src_i    (src),
            .func_d_i (func_d_i[k]),
            .ser_d_i  (ser_in[k]),
            .ser_q_o  (ser_q[k]),
            .func_q_o (func_q_o[k])
        );
    end

    assign scan_out_o = ser_q[LAST];

endmodule

// File: rtl/shc_chain_chk.sv
// Module: assertion checker for shc_chain, attached with bind below.
// Observes the top ports and the flip-flop vector formed by the serial links.
module shc_chain_chk #(
    parameter int STAGES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shift_en_i,
    input logic              freeze_i,
    input logic              scan_in_i,
    input logic [STAGES-1:0] func_d_i,
    input logic [STAGES-1:0] func_q_o,
    input logic              scan_out_o,
    input logic [STAGES-1:0] ser_q
);

    logic [STAGES-1:0] shifted;

    // Expected flip-flop vector after one shift edge.
    always_comb shifted = {ser_q[STAGES-2:0], scan_in_i};

    // R1: outputs are zero in the first cycle after reset is released.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (func_q_o == '0 && scan_out_o == 1'b0));

    // R2: capture loads the functional inputs.
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en_i |=> ser_q == $past(func_d_i));

    // R3: shift moves each stage one place along the chain.
    a_r3_shift: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en_i |=> ser_q == $past(shifted));

    // R6: the parallel outputs do not move while freeze stays high.
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_i |=> (!freeze_i || $stable(func_q_o)));

    // R7: shifting under freeze still moves the serial output.
    a_r7_shift_under_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && shift_en_i) |=> scan_out_o == $past(ser_q[STAGES-2]));

endmodule

bind shc_chain shc_chain_chk #(.STAGES(STAGES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en_i (shift_en_i),
    .freeze_i   (freeze_i),
    .scan_in_i  (scan_in_i),
    .func_d_i   (func_d_i),
    .func_q_o   (func_q_o),
    .scan_out_o (scan_out_o),
    .ser_q      (ser_q)
);

// File: tb/shc_chain_tb.sv
// Bench for shc_chain: directed corner cases, then seeded random stimulus,
// all compared against a bench model of flip-flops and frozen values.
module shc_chain_tb;

    localparam int N = 8;
    localparam int CLK_HALF = 5;   // 100 MHz
    localparam int RAND_CYCLES = 3000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         shift_en_i;
    logic         freeze_i;
    logic         scan_in_i;
    logic [N-1:0] func_d_i;
    logic [N-1:0] func_q_o;
    logic         scan_out_o;

    int checks = 0;
    int errors = 0;

    logic [N-1:0] m_ff;   // model of the flip-flops
    logic [N-1:0] m_frz;  // model of the frozen values

    always #CLK_HALF clk = ~clk;

    shc_chain #(.STAGES(N)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (shift_en_i),
        .freeze_i   (freeze_i),
        .scan_in_i  (scan_in_i),
        .func_d_i   (func_d_i),
        .func_q_o   (func_q_o),
        .scan_out_o (scan_out_o)
    );

    // Next flip-flop vector from the requirements (R2, R3).
    function automatic logic [N-1:0] f_next(logic [N-1:0] ff, logic sh,
                                            logic si, logic [N-1:0] d);
        return sh ? {ff[N-2:0], si} : d;
    endfunction

    // Expected parallel output (R5, R6).
    function automatic logic [N-1:0] f_out(logic [N-1:0] ff, logic [N-1:0] frz,
                                           logic frz_on);
        return frz_on ? frz : ff;
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance one edge and update the model with the inputs in effect.
    task automatic tick();
        logic [N-1:0] nx;
        @(posedge clk);
        nx = f_next(m_ff, shift_en_i, scan_in_i, func_d_i);
        if (!rst_n) begin
            m_ff  = '0;
            m_frz = '0;
        end else begin
            if (!freeze_i) m_frz = nx;
            m_ff = nx;
        end
        #1;
    endtask

    // Compare both outputs with the model; req names the output rule.
    task automatic check_outs(string req);
        #1;
        check(req, func_q_o, f_out(m_ff, m_frz, freeze_i));
        check("R4", {{(N-1){1'b0}}, scan_out_o}, {{(N-1){1'b0}}, m_ff[N-1]});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(2 * CLK_HALF * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        m_ff = '0;
        m_frz = '0;
        rst_n = 1'b0;
        shift_en_i = 1'b1;
        freeze_i = 1'b1;
        scan_in_i = 1'b1;
        func_d_i = '1;
        repeat (3) tick();

        // R1 and R9: reset taken with freeze high clears everything.
        #1;
        check("R1", func_q_o, '0);
        check("R1", {{(N-1){1'b0}}, scan_out_o}, '0);
        check("R9", func_q_o, '0);

        // R2 and R5: capture with freeze low shows up right after the edge.
        rst_n = 1'b1;
        freeze_i = 1'b0;
        shift_en_i = 1'b0;
        func_d_i = 8'hA5;
        tick();
        #1;
        check("R2", func_q_o, 8'hA5);
        check_outs("R5");

        // R6: freeze rises, then a full shift of ones passes through.
        freeze_i = 1'b1;
        shift_en_i = 1'b1;
        scan_in_i = 1'b1;
        #1;
        check("R6", func_q_o, 8'hA5);
        for (int i = 0; i < N; i++) begin
            tick();
            check_outs("R6");
            check("R6", func_q_o, 8'hA5);
        end
        // R4: the serial output moved although the outputs were frozen.
        check("R4", {{(N-1){1'b0}}, scan_out_o}, 8'h01);

        // R7: capture under freeze, seen on release.
        shift_en_i = 1'b0;
        func_d_i = 8'h3C;
        tick();
        check_outs("R6");
        check("R6", func_q_o, 8'hA5);

        // R8: release with no edge shows the flip-flops at once.
        freeze_i = 1'b0;
        #1;
        check("R8", func_q_o, 8'h3C);
        check("R7", func_q_o, m_ff);

        // R3: shift with freeze low, pattern moves toward the last stage.
        shift_en_i = 1'b1;
        scan_in_i = 1'b0;
        tick();
        check_outs("R3");
        check("R3", func_q_o, 8'h78);

        // Random phase: all controls change independently each cycle.
        for (int c = 0; c < RAND_CYCLES; c++) begin
            rst_n      = ($urandom_range(0, 63) != 0);
            shift_en_i = $urandom_range(0, 1) == 1;
            freeze_i   = $urandom_range(0, 2) != 0;
            scan_in_i  = $urandom_range(0, 1) == 1;
            func_d_i   = N'($urandom);
            check_outs(freeze_i ? "R6" : "R5");
            tick();
            check_outs(freeze_i ? "R7" : "R8");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule